// File: doc/BRIEF.md
# Adaptive Rank Order Impulse Filter

This block restores one grayscale pixel at a time in images corrupted by salt-and-pepper noise. A caller presents the square neighbourhood around the pixel being restored, which is 9x9 by default, together with a one-cycle valid strobe. The block holds the neighbourhood internally and raises busy. When it has decided the output value, it pulses done for one cycle. Line buffers, image memory and splitting colour planes are left to the surrounding pipeline. Results go to a separate output, so a restored value never feeds back into the neighbourhood of a later pixel.

A pixel whose value is at either end of the code range counts as an impulse. A clean center pixel is passed through as it is. A noisy center is handled with nested windows that share the same center. The block starts with a 3x3 window. It ranks every pixel of that window serially, one candidate per cycle, by counting how many window pixels are smaller than the candidate and how many are equal to it. From these counts it finds the minimum, the median and the maximum.

- If the median lies strictly between the minimum and the maximum, the median is the output.
- If the median fails that test and the window holds at least one clean pixel, a second pass picks the clean pixel nearest to the median.
- If every pixel in the window is an impulse, the window grows by two in each dimension and ranking starts again.

Top module: `arof_filter`

## Requirements
- R1: A pixel counts as an impulse exactly when its value is 0 or the maximum code (255 for 8-bit pixels). The values 1 and 254 are clean.
- R2: A clean center pixel is output unchanged with res_flag low. Counting the edge that accepts the window as edge 1, done rises on edge 2.
- R3: For the current window of n pixels, min and max are the extreme values, and the median is the value of ascending rank (n-1)/2, counting from zero. The median is the output exactly when min < median < max holds strictly.
- R4: When the median is rejected and the current window holds at least one clean pixel, the output is the clean pixel with the smallest absolute difference from the median. On a tie, the smaller value wins.
- R5: The window grows through 3x3, 5x5, 7x7 and 9x9 only when every pixel of the current window is an impulse. Pixels outside the window that produces the result have no effect on the output.
- R6: When even the 9x9 window holds only impulses, the output is the original center value with res_flag high. Every other result has res_flag low.
- R7: A window is accepted when win_valid is high on an edge while busy is low. busy is high from the next cycle through the cycle in which done is high. done lasts one cycle, and busy is low in the cycle after it. win_valid is ignored while busy is high.
- R8: Each new center pixel starts at the 3x3 window, whatever window size the previous pixel reached.
- R9: Pixel (row r, column c) of the neighbourhood sits at win_pix bits [(r*9+c)*8 +: 8], in row-major order. The center is at row 4, column 4, which is index 40.
- R10: A center that a 3x3 median resolves raises done on edge 12, counting the accepting edge as 1. A center that the 3x3 nearest-clean pass resolves raises done on edge 21.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| win_valid | input | 1 | Strobe: win_pix holds a new neighbourhood |
| win_pix | input | 648 | 9x9 neighbourhood of 8-bit pixels, row-major |
| busy | output | 1 | High while a pixel is being decided |
| done | output | 1 | One-cycle pulse: res_pix and res_flag are valid |
| res_pix | output | 8 | Restored center value, held until the next result |
| res_flag | output | 1 | High when the 9x9 window held only impulses |

## Verification
The bench aims at the codes next to the impulse values:
- A design that treats 1 or 254 as noise would grow the window where it should have kept a clean pixel.
- A non-strict median test would accept a median equal to the window maximum instead of substituting a clean pixel.

It also covers the growth corners:
- A window that resolves only at 5x5 or only at 9x9.
- A fully noisy neighbourhood, which must set the flag and return the center.
- A pixel decided right after a 9x9 case. A missing reset of the window size would rank a larger window there and return a different value.

Finally, the bench changes win_valid and win_pix while busy is high. A design that latched the second window would return that window's value. Randomized neighbourhoods at several noise densities are compared against a sorting reference model.

// File: rtl/arof_pkg.sv
package arof_pkg;

  // Sequencer states of the per-pixel decision engine
  typedef enum logic [2:0] {
    ST_IDLE,   // waiting for a neighbourhood
    ST_CHECK,  // test the center pixel
    ST_RANK,   // serial ranking pass over the current window
    ST_EVAL,   // decide: accept median, grow, give up or search nearest
    ST_NEAR,   // serial pass for the clean pixel nearest the median
    ST_DONE    // result presented for one cycle
  } arof_state_e;

endpackage

// File: rtl/arof_win_mask.sv
// Membership mask of the square window of half-size `half` centred in the
// neighbourhood array.
module arof_win_mask #(
  parameter int MAX_HALF = 4,
  parameter int HW       = $clog2(MAX_HALF + 1)
) (
  input  logic [HW-1:0]                            half,
  output logic [(2*MAX_HALF+1)*(2*MAX_HALF+1)-1:0] mask
);
  localparam int SIDE = 2 * MAX_HALF + 1;

  for (genvar r = 0; r < SIDE; r++) begin : g_row
    for (genvar c = 0; c < SIDE; c++) begin : g_col
      localparam int DR = (r > MAX_HALF) ? (r - MAX_HALF) : (MAX_HALF - r);
      localparam int DC = (c > MAX_HALF) ? (c - MAX_HALF) : (MAX_HALF - c);
      assign mask[r*SIDE + c] = (HW'(DR) <= half) && (HW'(DC) <= half);
    end
  end

endmodule

// File: rtl/arof_rank_count.sv
// Counting ranker: how many window pixels are below / equal to a candidate.
module arof_rank_count #(
  parameter int PIX_W = 8,
  parameter int NPIX  = 81,
  parameter int CW    = $clog2(NPIX + 1)
) (
  input  logic [NPIX*PIX_W-1:0] pix,
  input  logic [NPIX-1:0]       mask,
  input  logic [PIX_W-1:0]      cand,
  output logic [CW-1:0]         lt_cnt,
  output logic [CW-1:0]         eq_cnt
);

  always_comb begin
    lt_cnt = '0;
    eq_cnt = '0;
    for (int j = 0; j < NPIX; j++) begin
      if (mask[j] && (pix[j*PIX_W +: PIX_W] < cand)) lt_cnt = lt_cnt + CW'(1);
      if (mask[j] && (pix[j*PIX_W +: PIX_W] == cand)) eq_cnt = eq_cnt + CW'(1);
    end
  end

endmodule

// File: rtl/arof_nearest_sel.sv
// Decides whether a candidate displaces the best clean pixel found so far.
module arof_nearest_sel #(
  parameter int PIX_W = 8
) (
  input  logic [PIX_W-1:0] cand,
  input  logic             cand_clean,
  input  logic [PIX_W-1:0] med,
  input  logic [PIX_W-1:0] best,
  input  logic             best_vld,
  output logic             take
);

  function automatic logic [PIX_W-1:0] abs_diff(input logic [PIX_W-1:0] a,
                                                input logic [PIX_W-1:0] b);
    return (a > b) ? (a - b) : (b - a);
  endfunction

  logic [PIX_W-1:0] d_cand;
  logic [PIX_W-1:0] d_best;

  always_comb begin
    d_cand = abs_diff(cand, med);
    d_best = abs_diff(best, med);
    take   = cand_clean &&
             (!best_vld || (d_cand < d_best) ||
              ((d_cand == d_best) && (cand < best)));
  end

endmodule

// File: rtl/arof_filter.sv
module arof_filter
  import arof_pkg::*;
#(
  parameter int PIX_W    = 8,
  parameter int MAX_HALF = 4
) (
  input  logic                                               clk,
  input  logic                                               rst_n,
  input  logic                                               win_valid,
  input  logic [(2*MAX_HALF+1)*(2*MAX_HALF+1)*PIX_W-1:0]     win_pix,
  output logic                                               busy,
  output logic                                               done,
  output logic [PIX_W-1:0]                                   res_pix,
  output logic                                               res_flag
);

  localparam int SIDE = 2 * MAX_HALF + 1;
  localparam int NPIX = SIDE * SIDE;
  localparam int CTR  = MAX_HALF * SIDE + MAX_HALF;
  localparam int HW   = $clog2(MAX_HALF + 1);
  localparam int CW   = $clog2(NPIX + 1);
  localparam int IW   = $clog2(SIDE);
  localparam logic [PIX_W-1:0] PMAX = {PIX_W{1'b1}};

  function automatic logic is_impulse(input logic [PIX_W-1:0] v);
    return (v == '0) || (v == PMAX);
  endfunction

  arof_state_e             st_q;
  logic [NPIX*PIX_W-1:0]   pix_q;
  logic [HW-1:0]           half_q;
  logic [IW-1:0]           ri_q, ci_q;
  logic [PIX_W-1:0]        min_q, max_q, med_q, best_q;
  logic                    best_vld_q;
  logic [CW-1:0]           nf_q;
  logic [PIX_W-1:0]        res_pix_q;
  logic                    res_flag_q;

  // scan geometry
  int                      side_m1, row_i, col_i, idx_i, mid_i;
  logic [PIX_W-1:0]        cand, center;
  logic                    cand_clean, first_pos, last_pos;
  logic [IW-1:0]           ri_nxt, ci_nxt;

  always_comb begin
    side_m1 = 2 * int'(half_q);
    row_i   = MAX_HALF - int'(half_q) + int'(ri_q);
    col_i   = MAX_HALF - int'(half_q) + int'(ci_q);
    idx_i   = row_i * SIDE + col_i;
    if (idx_i < 0 || idx_i >= NPIX) idx_i = CTR;
    mid_i   = 2 * int'(half_q) * (int'(half_q) + 1);
    cand       = pix_q[idx_i*PIX_W +: PIX_W];
    center     = pix_q[CTR*PIX_W +: PIX_W];
    cand_clean = !is_impulse(cand);
    first_pos  = (ri_q == '0) && (ci_q == '0);
    last_pos   = (int'(ri_q) == side_m1) && (int'(ci_q) == side_m1);
    if (int'(ci_q) == side_m1) begin
      ci_nxt = '0;
      ri_nxt = ri_q + IW'(1);
    end else begin
      ci_nxt = ci_q + IW'(1);
      ri_nxt = ri_q;
    end
  end

  // window membership and counting ranker
  logic [NPIX-1:0] win_mask;
  logic [CW-1:0]   lt_cnt, eq_cnt;
  logic            take;

  arof_win_mask #(.MAX_HALF(MAX_HALF), .HW(HW)) u_mask (
    .half (half_q),
    .mask (win_mask)
  );

  arof_rank_count #(.PIX_W(PIX_W), .NPIX(NPIX), .CW(CW)) u_rank (
    .pix    (pix_q),
    .mask   (win_mask),
    .cand   (cand),
    .lt_cnt (lt_cnt),
    .eq_cnt (eq_cnt)
  );

  arof_nearest_sel #(.PIX_W(PIX_W)) u_near (
    .cand       (cand),
    .cand_clean (cand_clean),
    .med        (med_q),
    .best       (best_q),
    .best_vld   (best_vld_q),
    .take       (take)
  );

  // named decision events
  logic [CW-1:0] mid_c;
  logic          med_hit, med_ok, at_max_win;
  logic          eval_accept, eval_grow, eval_giveup, eval_near;

  always_comb begin
    mid_c       = CW'(mid_i);
    med_hit     = (lt_cnt <= mid_c) && (mid_c < (lt_cnt + eq_cnt));
    med_ok      = (min_q < med_q) && (med_q < max_q);
    at_max_win  = (half_q == HW'(MAX_HALF));
    eval_accept = (st_q == ST_EVAL) && med_ok;
    eval_grow   = (st_q == ST_EVAL) && !med_ok && (nf_q == '0) && !at_max_win;
    eval_giveup = (st_q == ST_EVAL) && !med_ok && (nf_q == '0) && at_max_win;
    eval_near   = (st_q == ST_EVAL) && !med_ok && (nf_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      pix_q      <= '0;
      half_q     <= '0;
      ri_q       <= '0;
      ci_q       <= '0;
      min_q      <= '0;
      max_q      <= '0;
      med_q      <= '0;
      best_q     <= '0;
      best_vld_q <= 1'b0;
      nf_q       <= '0;
      res_pix_q  <= '0;
      res_flag_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (win_valid) begin
            pix_q <= win_pix;
            st_q  <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          half_q <= HW'(1);
          ri_q   <= '0;
          ci_q   <= '0;
          nf_q   <= '0;
          if (!is_impulse(center)) begin
            res_pix_q  <= center;
            res_flag_q <= 1'b0;
            st_q       <= ST_DONE;
          end else begin
            st_q <= ST_RANK;
          end
        end
        ST_RANK: begin
          if (first_pos || cand < min_q) min_q <= cand;
          if (first_pos || cand > max_q) max_q <= cand;
          if (med_hit) med_q <= cand;
          if (cand_clean) nf_q <= nf_q + CW'(1);
          ri_q <= ri_nxt;
          ci_q <= ci_nxt;
          if (last_pos) st_q <= ST_EVAL;
        end
        ST_EVAL: begin
          ri_q <= '0;
          ci_q <= '0;
          if (eval_accept) begin
            res_pix_q  <= med_q;
            res_flag_q <= 1'b0;
            st_q       <= ST_DONE;
          end else if (eval_giveup) begin
            res_pix_q  <= center;
            res_flag_q <= 1'b1;
            st_q       <= ST_DONE;
          end else if (eval_grow) begin
            half_q <= half_q + HW'(1);
            nf_q   <= '0;
            st_q   <= ST_RANK;
          end else begin
            best_vld_q <= 1'b0;
            st_q       <= ST_NEAR;
          end
        end
        ST_NEAR: begin
          if (take) begin
            best_q     <= cand;
            best_vld_q <= 1'b1;
          end
          ri_q <= ri_nxt;
          ci_q <= ci_nxt;
          if (last_pos) begin
            res_pix_q  <= take ? cand : best_q;
            res_flag_q <= 1'b0;
            st_q       <= ST_DONE;
          end
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (st_q != ST_IDLE);
  assign done     = (st_q == ST_DONE);
  assign res_pix  = res_pix_q;
  assign res_flag = res_flag_q;

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && win_valid) |=> busy);
  // R7
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  // R6
  giveup_impulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res_flag) |-> is_impulse(res_pix));
  // R1
  clean_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !res_flag) |-> !is_impulse(res_pix));
  // R3
  median_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eval_accept |=> (done && (res_pix == $past(med_q))));
  // R3
  noisy_median_rejected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_EVAL) && (nf_q == '0)) |-> !med_ok);
  // R5
  no_grow_with_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_EVAL) && (nf_q != '0)) |=> (half_q == $past(half_q)));

endmodule

// File: tb/arof_filter_bench.sv
`timescale 1ns/1ps
module arof_filter_bench;

  localparam int NP = 81;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            win_valid = 1'b0;
  logic [NP*8-1:0] win_pix = '0;
  logic            busy, done, res_flag;
  logic [7:0]      res_pix;

  int vectors = 0;
  int miscompares = 0;
  bit reported = 0;

  logic [7:0] w [NP];

  always #2.5 clk = ~clk;

  arof_filter u_arof_filter (
    .clk      (clk),
    .rst_n    (rst_n),
    .win_valid(win_valid),
    .win_pix  (win_pix),
    .busy     (busy),
    .done     (done),
    .res_pix  (res_pix),
    .res_flag (res_flag)
  );

  task automatic check(input bit ok, input string what, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    end
  endtask

  function automatic logic [NP*8-1:0] pack();
    logic [NP*8-1:0] f;
    for (int i = 0; i < NP; i++) f[i*8 +: 8] = w[i];
    return f;
  endfunction

  task automatic fill(input logic [7:0] v);
    for (int i = 0; i < NP; i++) w[i] = v;
  endtask

  task automatic put(input int r, input int c, input logic [7:0] v);
    w[r*9 + c] = v;
  endtask

  function automatic bit noisy(input int v);
    return (v == 0) || (v == 255);
  endfunction

  // reference: explicit sort per window size; returns {flag, value}
  function automatic logic [8:0] ref_model();
    int v [NP];
    int n, k, t, mn, mx, md, best, bd, d;
    int ctr;
    ctr = int'(w[40]);
    if (!noisy(ctr)) return {1'b0, 8'(ctr)};
    for (int h = 1; h <= 4; h++) begin
      n = 0;
      for (int r = 4 - h; r <= 4 + h; r++)
        for (int c = 4 - h; c <= 4 + h; c++) begin
          v[n] = int'(w[r*9 + c]);
          n++;
        end
      for (int i = 1; i < n; i++) begin
        t = v[i];
        k = i - 1;
        while (k >= 0 && v[k] > t) begin
          v[k+1] = v[k];
          k--;
        end
        v[k+1] = t;
      end
      mn = v[0]; mx = v[n-1]; md = v[(n-1)/2];
      if (mn < md && md < mx) return {1'b0, 8'(md)};
      best = -1; bd = 1000;
      for (int i = 0; i < n; i++) begin
        if (!noisy(v[i])) begin
          d = (v[i] > md) ? v[i] - md : md - v[i];
          if (d < bd) begin bd = d; best = v[i]; end
        end
      end
      if (best >= 0) return {1'b0, 8'(best)};
    end
    return {1'b1, 8'(ctr)};
  endfunction

  // apply current w, wait for done, check value, flag, handshake, latency
  task automatic run_window(input string req, input int exp_lat);
    logic [8:0] r;
    int  edges;
    bit  busy_ok, timed_out;
    r = ref_model();
    @(negedge clk);
    win_pix   = pack();
    win_valid = 1'b1;
    @(posedge clk);
    edges = 1; busy_ok = 1; timed_out = 0;
    forever begin
      @(negedge clk);
      win_valid = 1'b0;
      if (done) break;
      if (!busy) busy_ok = 0;
      if (edges > 4000) begin timed_out = 1; break; end
      @(posedge clk);
      edges++;
    end
    check(!timed_out, {req, " done timeout"}, edges, 0);
    check(res_pix == r[7:0], {req, " result"}, int'(res_pix), int'(r[7:0]));
    check(res_flag == r[8], {req, " R6 flag"}, int'(res_flag), int'(r[8]));
    check(busy_ok, {req, " R7 busy held until done"}, int'(busy_ok), 1);
    if (exp_lat > 0) check(edges == exp_lat, {req, " R10 latency"}, edges, exp_lat);
    @(negedge clk);
    check(!busy && !done, {req, " R7 idle after done"}, int'({busy, done}), 0);
  endtask

  // 3x3 ring 10..90 with noisy center 0 -> median 40
  task automatic set_core_median();
    put(3,3,10); put(3,4,20); put(3,5,30);
    put(4,3,40); put(4,4,0);  put(4,5,60);
    put(5,3,70); put(5,4,80); put(5,5,90);
  endtask

  task automatic t_reset();
    check(!busy && !done && res_pix == 0 && !res_flag, "R7 reset state",
          int'({busy, done, res_flag}), 0);
  endtask

  task automatic t_passthrough();
    fill(0); put(4,4,77);
    run_window("R2 clean center", 2);
    fill(255); put(4,4,254);
    run_window("R1 R2 value 254 clean", 2);
    fill(0); put(4,4,1);
    run_window("R1 R2 value 1 clean", 2);
  endtask

  task automatic t_median();
    fill(200); set_core_median();
    run_window("R3 median accepted", 12);
    check(res_pix == 40, "R3 median value", int'(res_pix), 40);
    // outside pixels noisy: no influence
    for (int i = 0; i < NP; i++) w[i] = (i % 3 == 0) ? 8'd0 : 8'd255;
    set_core_median();
    run_window("R5 outer pixels ignored", 12);
    check(res_pix == 40, "R5 outer ignored value", int'(res_pix), 40);
  endtask

  task automatic t_nearest();
    // median 255 is an impulse -> nearest clean 120
    fill(255);
    put(3,3,0); put(3,4,30); put(3,5,90); put(4,3,120);
    run_window("R4 nearest to noisy median", 21);
    check(res_pix == 120, "R4 nearest value", int'(res_pix), 120);
    // median equals max (not strict) -> clean 50 kept
    fill(0); put(4,4,0);
    for (int r = 3; r <= 5; r++) for (int c = 3; c <= 5; c++) if (!(r == 4 && c == 4)) put(r,c,50);
    run_window("R3 R4 median equals max", 21);
    check(res_pix == 50, "R3 non-strict rejected", int'(res_pix), 50);
    // only clean value 1 in 3x3 -> no growth
    fill(0); put(4,4,255); put(3,3,1); put(1,1,100);
    run_window("R1 R4 value 1 is clean", 21);
    check(res_pix == 1, "R1 clean 1 used", int'(res_pix), 1);
    // indexing: (3,5) inside 3x3, (5,6) outside
    fill(0); put(4,4,255); put(3,5,77); put(5,6,33);
    run_window("R9 row-major index", 21);
    check(res_pix == 77, "R9 index value", int'(res_pix), 77);
  endtask

  task automatic t_grow();
    fill(0); put(4,4,255);
    put(2,2,40); put(2,6,90); put(6,4,70);
    run_window("R5 grow to 5x5", 63);
    check(res_pix == 40, "R5 5x5 value", int'(res_pix), 40);
    fill(255); put(4,4,0); put(0,8,123); put(8,0,200);
    run_window("R5 grow to 9x9", 0);
    check(res_pix == 200, "R5 9x9 value", int'(res_pix), 200);
    // next pixel must start at 3x3 again
    fill(200); set_core_median();
    run_window("R8 window reset", 12);
    check(res_pix == 40, "R8 restarted at 3x3", int'(res_pix), 40);
  endtask

  task automatic t_all_noisy();
    for (int r = 0; r < 9; r++) for (int c = 0; c < 9; c++) put(r, c, ((r + c) % 2 == 0) ? 8'd0 : 8'd255);
    run_window("R6 all noisy", 0);
    check(res_flag == 1'b1 && res_pix == 0, "R6 give up flag and center",
          int'({res_flag, res_pix}), 256);
    fill(0); put(4,4,99);
    run_window("R6 flag cleared", 2);
    check(res_flag == 1'b0, "R6 flag low after normal", int'(res_flag), 0);
  endtask

  task automatic t_busy_ignore();
    logic [8:0] r;
    logic [NP*8-1:0] fa, fb;
    int cyc;
    fill(200); set_core_median();
    r = ref_model(); fa = pack();
    fill(0); put(4,4,150); fb = pack();
    @(negedge clk); win_pix = fa; win_valid = 1'b1;
    @(posedge clk);
    @(negedge clk); win_pix = fb; win_valid = 1'b1;
    repeat (3) @(negedge clk);
    win_valid = 1'b0;
    cyc = 0;
    while (!done && cyc < 4000) begin @(negedge clk); cyc++; end
    check(done && res_pix == r[7:0], "R7 valid ignored while busy",
          int'(res_pix), int'(r[7:0]));
    @(negedge clk);
    check(!busy, "R7 no restart from ignored valid", int'(busy), 0);
  endtask

  task automatic t_random();
    int dens;
    for (int t = 0; t < 32; t++) begin
      dens = 30 + 20 * (t % 4);
      for (int i = 0; i < NP; i++) begin
        if ($urandom_range(0, 99) < dens) w[i] = $urandom_range(0, 1) ? 8'd255 : 8'd0;
        else w[i] = 8'($urandom_range(1, 254));
      end
      if (t % 4 != 0) w[40] = (t % 2 == 0) ? 8'd0 : 8'd255;
      run_window("R3 R4 R5 random", 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    report();
    $finish;
  end

  initial begin
    void'($urandom(7));
    fill(0);
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_passthrough();
    t_median();
    t_nearest();
    t_grow();
    t_all_noisy();
    t_busy_ignore();
    t_random();
    report();
    $finish;
  end

endmodule